// File: doc/BRIEF.md
# Shared-Bus Register Bank

This block holds the programmer-visible registers of a small accumulator machine and a word-addressed memory. All of them hang on a single 16-bit data bus. In any cycle a 3-bit source code picks at most one register to drive the bus, and a 3-bit destination code picks at most one register to load from it on the next rising edge. Code zero means "no register". Memory has its own strobes: a read strobe puts the word addressed by the address register onto the bus, and a write strobe stores the bus value at that address.

Two registers are 12 bits wide: the address register and the program counter. They take the low 12 bits of the bus and drive the bus zero-extended. The block exports the address register as a 12-bit address bus and the top nibble of the instruction register as a 4-bit opcode bus. It also exports the decoded select wires for each side. An external ALU and sequencer sit outside the block. Two direct-load ports let the ALU overwrite the program counter and the accumulator without using the bus.

Top module: `shared_bus_bank`

## Requirements
- R1: A synchronous reset clears all seven registers to zero, so every source code reads 0 on the bus afterwards.
- R2: Source code 1=address reg, 2=program counter, 3=buffer reg, 4=accumulator, 5=input reg, 6=output reg, 7=instruction reg drives that register onto `data_bus` in the same cycle. The 12-bit registers (codes 1 and 2) appear zero-extended.
- R3: Destination code n (same numbering) loads `data_bus` into that register on the rising edge. Codes 1 and 2 keep only bus bits [11:0].
- R4: Code 0 selects no register. With source 0 and no memory read, the bus is 0. With destination 0, no register changes.
- R5: `rd_wires[i]` equals bit i of the source code and `wr_wires[i]` equals bit i of the destination code, for i = 0..2.
- R6: With `mem_rd` high and source 0, the memory word at the address register drives `data_bus`.
- R7: With `mem_wr` high, the bus value is stored at the address register's value on the rising edge. Other addresses are left unchanged.
- R8: `addr_bus` always equals the address register, and `opcode_bus` always equals instruction register bits [15:12].
- R9: `bus_conflict` is 1 exactly when `mem_rd` is high and the source code is non-zero. In that case the selected register still drives the bus.
- R10: `pc_ld` loads `pc_ld_val` and `ac_ld` loads `ac_ld_val` on the rising edge. Each direct load takes priority over a bus write to the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_sel | input | 3 | Bus source code |
| wr_sel | input | 3 | Bus destination code |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| pc_ld | input | 1 | Direct load of program counter |
| pc_ld_val | input | 12 | Value for direct PC load |
| ac_ld | input | 1 | Direct load of accumulator |
| ac_ld_val | input | 16 | Value for direct accumulator load |
| data_bus | output | 16 | Shared data bus value |
| addr_bus | output | 12 | Address register contents |
| opcode_bus | output | 4 | Instruction register bits [15:12] |
| rd_wires | output | 3 | Decoded source select wires |
| wr_wires | output | 3 | Decoded destination select wires |
| bus_conflict | output | 1 | Register and memory both asked to drive the bus |

## Verification
The assertions check several properties on every cycle. An idle bus reads zero. A bus write to the accumulator or address register lands the previous bus value. Direct loads take effect. The program counter holds when nothing targets it. A memory write is readable at its address one cycle later. The bench scenarios cover what needs a sequence to observe: reset values read back through every code, zero-extension and truncation of the 12-bit registers, memory addresses left untouched by a neighbouring write, the decoded wires for all eight codes, and the conflict flag against register and memory traffic.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int SEL_W  = 3;
    localparam int OPC_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_NONE = 3'd0,
        SEL_MAR  = 3'd1,
        SEL_PC   = 3'd2,
        SEL_MBR  = 3'd3,
        SEL_AC   = 3'd4,
        SEL_IN   = 3'd5,
        SEL_OUT  = 3'd6,
        SEL_IR   = 3'd7
    } sel_code_e;

    typedef struct packed {
        logic [ADDR_W-1:0] mar;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] inr;
        logic [DATA_W-1:0] outr;
        logic [DATA_W-1:0] ir;
    } reg_file_t;
endpackage

// File: rtl/sel_wires.sv
module sel_wires #(
    parameter int W = 3
) (
    input  logic [W-1:0] code,
    output logic [W-1:0] wires
);
    // Each wire mirrors one binary bit of the select code
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign wires[i] = code[i];
    end
endmodule

// File: rtl/word_mem.sv
module word_mem #(
    parameter int AW = bank_pkg::ADDR_W,
    parameter int DW = bank_pkg::DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] mem_q [DEPTH];
    logic          we_eff;

    assign we_eff = we && !rst;
    assign dout   = mem_q[addr];

    always_ff @(posedge clk) begin
        if (we_eff) begin
            mem_q[addr] <= din;
        end
    end

    // R7: a stored word is visible at its address on the next cycle
    a_r7_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(addr)] == $past(din));
endmodule

// File: rtl/bus_mux.sv
module bus_mux
    import bank_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    localparam int PAD = DW - AW
) (
    input  reg_file_t        regs,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             mem_rd,
    input  logic [DW-1:0]    mem_word,
    output logic [DW-1:0]    bus,
    output logic             conflict
);
    always_comb begin
        bus = '0;
        case (sel_code_e'(rd_sel))
            SEL_MAR:  bus = {{PAD{1'b0}}, regs.mar};
            SEL_PC:   bus = {{PAD{1'b0}}, regs.pc};
            SEL_MBR:  bus = regs.mbr;
            SEL_AC:   bus = regs.ac;
            SEL_IN:   bus = regs.inr;
            SEL_OUT:  bus = regs.outr;
            SEL_IR:   bus = regs.ir;
            default:  bus = mem_rd ? mem_word : '0;
        endcase
        conflict = mem_rd && (rd_sel != SEL_NONE);
    end
endmodule

// File: rtl/shared_bus_bank.sv
module shared_bus_bank
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        rd_sel,
    input  logic [2:0]        wr_sel,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic              pc_ld,
    input  logic [11:0]       pc_ld_val,
    input  logic              ac_ld,
    input  logic [15:0]       ac_ld_val,
    output logic [15:0]       data_bus,
    output logic [11:0]       addr_bus,
    output logic [3:0]        opcode_bus,
    output logic [2:0]        rd_wires,
    output logic [2:0]        wr_wires,
    output logic              bus_conflict
);
    reg_file_t         regs_d, regs_q;
    logic [DATA_W-1:0] mem_word;

    sel_wires #(.W(SEL_W)) i_rd_wires (.code(rd_sel), .wires(rd_wires));
    sel_wires #(.W(SEL_W)) i_wr_wires (.code(wr_sel), .wires(wr_wires));

    bus_mux i_bus_mux (
        .regs     (regs_q),
        .rd_sel   (rd_sel),
        .mem_rd   (mem_rd),
        .mem_word (mem_word),
        .bus      (data_bus),
        .conflict (bus_conflict)
    );

    word_mem #(.AW(ADDR_W), .DW(DATA_W)) i_mem (
        .clk  (clk),
        .rst  (rst),
        .addr (regs_q.mar),
        .we   (mem_wr),
        .din  (data_bus),
        .dout (mem_word)
    );

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else begin
            case (sel_code_e'(wr_sel))
                SEL_MAR: regs_d.mar  = data_bus[ADDR_W-1:0];
                SEL_PC:  regs_d.pc   = data_bus[ADDR_W-1:0];
                SEL_MBR: regs_d.mbr  = data_bus;
                SEL_AC:  regs_d.ac   = data_bus;
                SEL_IN:  regs_d.inr  = data_bus;
                SEL_OUT: regs_d.outr = data_bus;
                SEL_IR:  regs_d.ir   = data_bus;
                default: ;
            endcase
            if (pc_ld) regs_d.pc = pc_ld_val;
            if (ac_ld) regs_d.ac = ac_ld_val;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign addr_bus   = regs_q.mar;
    assign opcode_bus = regs_q.ir[DATA_W-1 -: OPC_W];

    // R4: nothing selected and no memory read leaves the bus at zero
    a_r4_idle_bus_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 3'd0 && !mem_rd) |-> data_bus == '0);

    // R3: a bus write into the accumulator captures the bus value
    a_r3_ac_from_bus: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == 3'd4 && !ac_ld) |=> regs_q.ac == $past(data_bus));

    // R8: address bus follows a bus write into the address register
    a_r8_addr_follows: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == 3'd1) |=> addr_bus == $past(data_bus[11:0]));

    // R10: direct loads win
    a_r10_ac_direct: assert property (@(posedge clk) disable iff (rst)
        ac_ld |=> regs_q.ac == $past(ac_ld_val));
    a_r10_pc_direct: assert property (@(posedge clk) disable iff (rst)
        pc_ld |=> regs_q.pc == $past(pc_ld_val));

    // R4: program counter holds when nothing targets it
    a_r4_pc_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_sel != 3'd2 && !pc_ld) |=> $stable(regs_q.pc));
endmodule

// File: tb/test_shared_bus_bank.sv
module test_shared_bus_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_sel, wr_sel;
    logic        mem_rd, mem_wr, pc_ld, ac_ld;
    logic [11:0] pc_ld_val;
    logic [15:0] ac_ld_val;
    logic [15:0] data_bus;
    logic [11:0] addr_bus;
    logic [3:0]  opcode_bus;
    logic [2:0]  rd_wires, wr_wires;
    logic        bus_conflict;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    shared_bus_bank i_shared_bus_bank (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_ld(pc_ld), .pc_ld_val(pc_ld_val),
        .ac_ld(ac_ld), .ac_ld_val(ac_ld_val), .data_bus(data_bus),
        .addr_bus(addr_bus), .opcode_bus(opcode_bus), .rd_wires(rd_wires),
        .wr_wires(wr_wires), .bus_conflict(bus_conflict)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge region, settle combinational outputs
    task automatic drive(input logic [2:0] rs, input logic [2:0] ws,
                         input logic mr, input logic mw);
        rd_sel = rs; wr_sel = ws; mem_rd = mr; mem_wr = mw;
        pc_ld = 1'b0; ac_ld = 1'b0;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(input logic [2:0] rs, input logic [2:0] ws,
                        input logic mr, input logic mw);
        drive(rs, ws, mr, mw);
        tick();
    endtask

    task automatic load_ac(input logic [15:0] v);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        ac_ld = 1'b1; ac_ld_val = v;
        tick();
        ac_ld = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [2:0] code, input logic [15:0] exp);
        drive(code, 3'd0, 1'b0, 1'b0);
        chk(req, data_bus, exp);
        tick();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        repeat (2) tick();
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int c = 1; c < 8; c++) read_chk("R1 reset value", 3'(c), 16'h0000);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        chk("R4 idle bus", data_bus, 16'h0000);
        chk("R8 addr after reset", {4'h0, addr_bus}, 16'h0000);
    endtask

    task automatic t_moves();
        load_ac(16'hBEEF);
        read_chk("R10 ac direct", 3'd4, 16'hBEEF);
        read_chk("R2 ac drive", 3'd4, 16'hBEEF);
        step(3'd4, 3'd1, 1'b0, 1'b0);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        chk("R8 addr bus", {4'h0, addr_bus}, 16'h0EEF);
        read_chk("R2 mar zero-extend", 3'd1, 16'h0EEF);
        step(3'd4, 3'd2, 1'b0, 1'b0);
        read_chk("R3 pc truncate", 3'd2, 16'h0EEF);
        step(3'd4, 3'd7, 1'b0, 1'b0);
        drive(3'd0, 3'd0, 1'b0, 1'b0);
        chk("R8 opcode bus", {12'h0, opcode_bus}, 16'h000B);
        step(3'd7, 3'd3, 1'b0, 1'b0);
        read_chk("R3 mbr load", 3'd3, 16'hBEEF);
        load_ac(16'h1357);
        step(3'd4, 3'd5, 1'b0, 1'b0);
        step(3'd5, 3'd6, 1'b0, 1'b0);
        read_chk("R3 in load", 3'd5, 16'h1357);
        read_chk("R3 out load", 3'd6, 16'h1357);
        read_chk("R3 ir unchanged", 3'd7, 16'hBEEF);
    endtask

    task automatic t_code_zero();
        load_ac(16'h4242);
        step(3'd4, 3'd0, 1'b0, 1'b0);
        read_chk("R4 mbr untouched", 3'd3, 16'hBEEF);
        read_chk("R4 in untouched", 3'd5, 16'h1357);
        read_chk("R4 out untouched", 3'd6, 16'h1357);
        read_chk("R4 ir untouched", 3'd7, 16'hBEEF);
        read_chk("R4 mar untouched", 3'd1, 16'h0EEF);
    endtask

    task automatic t_wires();
        for (int c = 0; c < 8; c++) begin
            drive(3'(c), 3'(7 - c), 1'b0, 1'b0);
            chk("R5 read wires", {13'h0, rd_wires}, 16'(c));
            chk("R5 write wires", {13'h0, wr_wires}, 16'(7 - c));
        end
        drive(3'd0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_memory();
        load_ac(16'h0006);
        step(3'd4, 3'd1, 1'b0, 1'b0);
        load_ac(16'h1111);
        step(3'd4, 3'd0, 1'b0, 1'b1);
        load_ac(16'h0005);
        step(3'd4, 3'd1, 1'b0, 1'b0);
        load_ac(16'hA5A5);
        step(3'd4, 3'd0, 1'b0, 1'b1);
        drive(3'd0, 3'd0, 1'b1, 1'b0);
        chk("R6 memory read", data_bus, 16'hA5A5);
        chk("R9 no conflict on memory read", {15'h0, bus_conflict}, 16'h0000);
        tick();
        step(3'd0, 3'd3, 1'b1, 1'b0);
        read_chk("R6 memory into mbr", 3'd3, 16'hA5A5);
        load_ac(16'h0006);
        step(3'd4, 3'd1, 1'b0, 1'b0);
        drive(3'd0, 3'd0, 1'b1, 1'b0);
        chk("R7 neighbour untouched", data_bus, 16'h1111);
        tick();
    endtask

    task automatic t_conflict();
        load_ac(16'h0F0F);
        drive(3'd4, 3'd0, 1'b1, 1'b0);
        chk("R9 conflict flag", {15'h0, bus_conflict}, 16'h0001);
        chk("R9 register wins bus", data_bus, 16'h0F0F);
        drive(3'd4, 3'd0, 1'b0, 1'b0);
        chk("R9 register only", {15'h0, bus_conflict}, 16'h0000);
        tick();
    endtask

    task automatic t_priority();
        drive(3'd3, 3'd4, 1'b0, 1'b0);
        ac_ld = 1'b1; ac_ld_val = 16'h7777;
        tick();
        read_chk("R10 ac priority", 3'd4, 16'h7777);
        drive(3'd4, 3'd2, 1'b0, 1'b0);
        pc_ld = 1'b1; pc_ld_val = 12'hABC;
        tick();
        read_chk("R10 pc priority", 3'd2, 16'h0ABC);
    endtask

    initial begin
        rst = 1'b1;
        pc_ld_val = '0; ac_ld_val = '0;
        rd_sel = '0; wr_sel = '0; mem_rd = 1'b0; mem_wr = 1'b0;
        pc_ld = 1'b0; ac_ld = 1'b0;
        @(negedge clk);
        t_reset();
        t_moves();
        t_code_zero();
        t_memory();
        t_conflict();
        t_priority();
        t_wires();
        do_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule